// File: doc/BRIEF.md
# Card Clock Divider With Update Handshake

This block produces the card bus clock of an SD/MMC-style host from the module clock. Software programs a staged clock setting: an enable bit and a divider value. The staged setting has no effect on the card clock until software sends an update-only command, which sets a start bit that clears itself. The block then waits for a safe moment, copies the staged setting into the live divider, drops the start bit and raises a sticky done flag. Software clears the flag by writing a one to it.

Because each update is applied separately, the usual sequence works step by step: turn the clock off, change the divider, then turn it back on, with one update after each step. An update can be told to hold off until an in-flight data transfer has ended. A live setting changes only while the divided clock is low, so a high phase that has already started always runs to full length. A divider value of N gives a clock of module clock / (2·N). The value 0 passes the module clock through ungated.

Top module: `sdclk_gen`

## Requirements
- R1: After reset, `card_clk` is low and both `start_bit` and `upd_done` are 0, with the clock disabled and no update pending.
- R2: A write on `ctl_wr` only updates the staged enable and divider values. The card clock and the live setting do not change until an update is applied.
- R3: A command write is accepted as an update only when `cmd_start` and `cmd_upd_only` are both 1 and no update is pending. Any other command write leaves `start_bit`, `upd_done` and `card_clk` unchanged.
- R4: `start_bit` reads 1 from the cycle after an accepted command until the update is applied. It returns to 0 on the same clock edge at which the staged setting becomes live.
- R5: Applying an update sets `upd_done`. The flag stays set until a cycle with `sts_clr` = 1. If an apply and a clear fall in the same cycle, the flag ends up set.
- R6: If `cmd_wait_prev` was 1 in the accepted command, the update is not applied while `xfer_busy` is 1. If it was 0, `xfer_busy` does not delay the update.
- R7: With the clock enabled and a divider value N ≥ 1, every high phase and every full low phase of `card_clk` lasts N module-clock cycles, giving a period of 2·N.
- R8: With the clock enabled and a divider value of 0, `card_clk` follows the module clock: high while it is high and low while it is low.
- R9: With the clock disabled, `card_clk` stays low.
- R10: An update is applied only while the divided output is low. A high phase already under way when the command arrives completes at the old full length.
- R11: The largest divider value, 2^DIV_W − 1 (255 by default), divides correctly. At the default width, 100 MHz gives both 400 kHz (N = 125) and 50 MHz (N = 1).
- R12: Disable, change divider and re-enable can each be applied by a separate update, and each takes effect on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the staged clock setting |
| ctl_en | input | 1 | Staged clock enable |
| ctl_div | input | DIV_W | Staged divider value (0 = pass-through) |
| cmd_wr | input | 1 | Command write strobe |
| cmd_start | input | 1 | Start bit of the command write |
| cmd_upd_only | input | 1 | Update-clock-only flag of the command write |
| cmd_wait_prev | input | 1 | Wait-for-previous-transfer flag of the command write |
| xfer_busy | input | 1 | A data transfer is in progress |
| sts_clr | input | 1 | Write-one-to-clear for the done flag |
| start_bit | output | 1 | Read-back of the self-clearing start bit |
| upd_done | output | 1 | Sticky update-complete status flag |
| card_clk | output | 1 | Card bus clock |

## Verification
Two events can land on the same cycle: the update being applied and software clearing the done flag. The bench sets this up with the clock disabled, since the apply edge then comes exactly one cycle after the command. It drives `sts_clr` on that edge and expects `upd_done` to be set afterwards. A second overlap comes from sending an update while the divided clock is high. In that case the live divider must not change until the high phase ends, so the scoreboard expects one pulse at the old width followed by pulses at the new width.

// File: rtl/sdclk_pkg.sv
// Shared definitions for the card clock generator.
// Assumes: divider value 0 means pass-through when enabled.
package sdclk_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_PASS = 2'd1,
        MODE_DIV  = 2'd2
    } clk_mode_e;

    // Decode the live setting into an operating mode.
    function automatic clk_mode_e cfg_mode(input logic en, input logic div_zero);
        if (!en)
            return MODE_OFF;
        else if (div_zero)
            return MODE_PASS;
        else
            return MODE_DIV;
    endfunction

endpackage

// File: rtl/sdclk_upd_ctl.sv
// Staged clock setting, update-only command handshake and done flag.
// Holds a staged copy of enable/divider and a live copy. The live copy is
// loaded from the staged one only when an accepted update is applied.
// Assumes: safe_pt comes from the divider and is high while its output is low.
module sdclk_upd_ctl #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_en,
    input  logic [DIV_W-1:0] ctl_div,
    input  logic             cmd_wr,
    input  logic             cmd_start,
    input  logic             cmd_upd_only,
    input  logic             cmd_wait_prev,
    input  logic             xfer_busy,
    input  logic             sts_clr,
    input  logic             safe_pt,
    output logic             apply,
    output logic             act_en,
    output logic [DIV_W-1:0] act_div,
    output logic             start_q,
    output logic             wait_q,
    output logic             done_q
);

    logic             stg_en;
    logic [DIV_W-1:0] stg_div;
    logic             accept;

    assign accept = cmd_wr && cmd_start && cmd_upd_only && !start_q;
    assign apply  = start_q && safe_pt && !(wait_q && xfer_busy);

    // Staged register: captures software writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_en  <= 1'b0;
            stg_div <= '0;
        end else if (ctl_wr) begin
            stg_en  <= ctl_en;
            stg_div <= ctl_div;
        end
    end

    // Self-clearing start bit with its latched wait flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            wait_q  <= 1'b0;
        end else if (apply) begin
            start_q <= 1'b0;
            wait_q  <= 1'b0;
        end else if (accept) begin
            start_q <= 1'b1;
            wait_q  <= cmd_wait_prev;
        end
    end

    // Live setting: loaded from the staged copy on apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_en  <= 1'b0;
            act_div <= '0;
        end else if (apply) begin
            act_en  <= stg_en;
            act_div <= stg_div;
        end
    end

    // Sticky done flag; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (apply)
            done_q <= 1'b1;
        else if (sts_clr)
            done_q <= 1'b0;
    end

endmodule

// File: rtl/sdclk_div.sv
// Divider and gate for the card clock.
// Divided mode toggles a register every act_div cycles. Pass-through mode
// gates the module clock with an enable captured on the falling edge, so
// the gate only moves while the module clock is low.
// Assumes: apply is only asserted while div_phase is low.
module sdclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply,
    input  logic             act_en,
    input  logic [DIV_W-1:0] act_div,
    output logic             div_phase,
    output logic             safe_pt,
    output logic             card_clk
);
    import sdclk_pkg::*;

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    clk_mode_e        mode;
    logic [DIV_W-1:0] cnt;
    logic             gate_q;

    assign mode    = cfg_mode(act_en, act_div == '0);
    assign safe_pt = !div_phase;

    // Phase counter: toggles the divided output every act_div cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            div_phase <= 1'b0;
        end else if (apply || mode != MODE_DIV) begin
            cnt       <= '0;
            div_phase <= 1'b0;
        end else if (cnt == act_div - ONE) begin
            cnt       <= '0;
            div_phase <= !div_phase;
        end else begin
            cnt       <= cnt + ONE;
        end
    end

    // Pass-through gate enable, updated while the module clock is low.
    always_ff @(negedge clk) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else
            gate_q <= (mode == MODE_PASS);
    end

    assign card_clk = (clk && gate_q) || div_phase;

endmodule

// File: rtl/sdclk_gen.sv
// Card clock generator top: staged setting, update handshake, divider.
// Assumes: a single module clock domain; register-level access is decoded
// outside this block into the strobes below.
module sdclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_en,
    input  logic [DIV_W-1:0] ctl_div,
    input  logic             cmd_wr,
    input  logic             cmd_start,
    input  logic             cmd_upd_only,
    input  logic             cmd_wait_prev,
    input  logic             xfer_busy,
    input  logic             sts_clr,
    output logic             start_bit,
    output logic             upd_done,
    output logic             card_clk
);

    logic             apply;
    logic             act_en;
    logic [DIV_W-1:0] act_div;
    logic             wait_flag;
    logic             div_phase;
    logic             safe_pt;

    sdclk_upd_ctl #(.DIV_W(DIV_W)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (ctl_wr),
        .ctl_en       (ctl_en),
        .ctl_div      (ctl_div),
        .cmd_wr       (cmd_wr),
        .cmd_start    (cmd_start),
        .cmd_upd_only (cmd_upd_only),
        .cmd_wait_prev(cmd_wait_prev),
        .xfer_busy    (xfer_busy),
        .sts_clr      (sts_clr),
        .safe_pt      (safe_pt),
        .apply        (apply),
        .act_en       (act_en),
        .act_div      (act_div),
        .start_q      (start_bit),
        .wait_q       (wait_flag),
        .done_q       (upd_done)
    );

    sdclk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply    (apply),
        .act_en   (act_en),
        .act_div  (act_div),
        .div_phase(div_phase),
        .safe_pt  (safe_pt),
        .card_clk (card_clk)
    );

endmodule

// File: rtl/sdclk_gen_chk.sv
// Property checker for sdclk_gen, attached by bind below.
// Assumes: the internal wires named in the bind exist in the top module.
module sdclk_gen_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_wr,
    input logic             cmd_start,
    input logic             cmd_upd_only,
    input logic             xfer_busy,
    input logic             sts_clr,
    input logic             start_bit,
    input logic             upd_done,
    input logic             apply,
    input logic             act_en,
    input logic [DIV_W-1:0] act_div,
    input logic             wait_flag,
    input logic             div_phase
);

    AST_LIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(act_en) && $stable(act_div)); // R2

    AST_BAD_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_bit && cmd_wr && !(cmd_start && cmd_upd_only)) |=> !start_bit); // R3

    AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (start_bit && !apply) |=> start_bit); // R4

    AST_APPLY_ENDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (!start_bit && upd_done)); // R5

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && !sts_clr) |=> upd_done); // R5

    AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_bit && wait_flag && xfer_busy) |-> !apply); // R6

    AST_RISE_NEEDS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_phase) |-> (act_en && act_div != '0)); // R7

    AST_OFF_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |-> !div_phase); // R9

    AST_APPLY_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        apply |-> !div_phase); // R10

endmodule

bind sdclk_gen sdclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .cmd_start   (cmd_start),
    .cmd_upd_only(cmd_upd_only),
    .xfer_busy   (xfer_busy),
    .sts_clr     (sts_clr),
    .start_bit   (start_bit),
    .upd_done    (upd_done),
    .apply       (apply),
    .act_en      (act_en),
    .act_div     (act_div),
    .wait_flag   (wait_flag),
    .div_phase   (div_phase)
);

// File: tb/test_sdclk_gen.sv
// Scoreboard bench: the driver queues expected phase widths and a monitor
// measures card_clk phases on falling edges and compares them.
module test_sdclk_gen;

    localparam int DIV_W = 8;
    localparam int DMAX  = (1 << DIV_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_wr = 1'b0, ctl_en = 1'b0;
    logic [DIV_W-1:0] ctl_div = '0;
    logic             cmd_wr = 1'b0, cmd_start = 1'b0, cmd_upd_only = 1'b0, cmd_wait_prev = 1'b0;
    logic             xfer_busy = 1'b0, sts_clr = 1'b0;
    logic             start_bit, upd_done, card_clk;

    int    errors = 0;
    int    checks = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    lo_ok = 1'b0;

    always #10 clk = !clk;

    sdclk_gen #(.DIV_W(DIV_W)) i_sdclk_gen (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_div(ctl_div),
        .cmd_wr(cmd_wr), .cmd_start(cmd_start), .cmd_upd_only(cmd_upd_only),
        .cmd_wait_prev(cmd_wait_prev), .xfer_busy(xfer_busy), .sts_clr(sts_clr),
        .start_bit(start_bit), .upd_done(upd_done), .card_clk(card_clk)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: measure phase widths and compare against the queue.
    logic prev_v = 1'b0;
    int   run = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_v = 1'b0;
            run    = 0;
        end else if (card_clk == prev_v) begin
            run++;
        end else begin
            if (exp_q.size() > 0 && (prev_v || lo_ok)) begin
                check(tag_q[0], run, exp_q[0]);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
            if (prev_v) lo_ok = 1'b1;
            prev_v = card_clk;
            run    = 1;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic stage(input bit en, input int div);
        ctl_wr = 1'b1; ctl_en = en; ctl_div = DIV_W'(div);
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic command(input bit s, input bit u, input bit w);
        cmd_wr = 1'b1; cmd_start = s; cmd_upd_only = u; cmd_wait_prev = w;
        tick();
        cmd_wr = 1'b0; cmd_start = 1'b0; cmd_upd_only = 1'b0; cmd_wait_prev = 1'b0;
    endtask

    task automatic wait_clear(input string tag, input int maxc);
        int n = 0;
        while (start_bit && n < maxc) begin
            tick();
            n++;
        end
        check(tag, start_bit, 0);
    endtask

    task automatic clear_done();
        sts_clr = 1'b1;
        tick();
        sts_clr = 1'b0;
    endtask

    // Driver: queue n expected phases of width w and wait for the monitor.
    task automatic expect_runs(input string tag, input int w, input int n);
        int c = 0;
        lo_ok = 1'b0;
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(w);
            tag_q.push_back(tag);
        end
        while (exp_q.size() > 0 && c < 4 * w * n + 40) begin
            tick();
            c++;
        end
        check({tag, " queue drained"}, exp_q.size(), 0);
    endtask

    task automatic update(input string tag, input bit w, input int maxc);
        command(1'b1, 1'b1, w);
        wait_clear(tag, maxc);
        check({tag, " done"}, upd_done, 1);
        clear_done();
    endtask

    function automatic int highs_at_posedge_window(input int dummy);
        return dummy;
    endfunction

    task automatic count_high(input int cyc, output int hi);
        hi = 0;
        for (int k = 0; k < cyc; k++) begin
            @(posedge clk);
            #2;
            if (card_clk) hi++;
            @(negedge clk);
            #1;
            if (card_clk) hi++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int hi;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1 card_clk", card_clk, 0);
        check("R1 start_bit", start_bit, 0);
        check("R1 upd_done", upd_done, 0);

        // R2: staged write alone changes nothing.
        stage(1'b1, 2);
        count_high(20, hi);
        check("R2 staged no effect", hi, 0);

        // R3: commands without both start and update-only are ignored.
        command(1'b1, 1'b0, 1'b1);
        check("R3 no upd flag start", start_bit, 0);
        command(1'b0, 1'b1, 1'b1);
        check("R3 no start start", start_bit, 0);
        count_high(10, hi);
        check("R3 card_clk idle", hi, 0);
        check("R3 done idle", upd_done, 0);

        // R4/R5: apply and clear in the same cycle; set must win.
        command(1'b1, 1'b1, 1'b1);
        check("R4 start set", start_bit, 1);
        sts_clr = 1'b1;
        tick();
        sts_clr = 1'b0;
        check("R4 start cleared", start_bit, 0);
        check("R5 set wins", upd_done, 1);
        expect_runs("R7 div2", 2, 6);
        check("R5 sticky", upd_done, 1);
        clear_done();
        check("R5 cleared", upd_done, 0);

        // R12: disable, change divider, re-enable, one update each.
        stage(1'b0, 2);
        update("R12 disable", 1'b1, 10);
        count_high(20, hi);
        check("R9 disabled low", hi, 0);
        stage(1'b0, 3);
        update("R12 divider", 1'b1, 10);
        count_high(20, hi);
        check("R12 still off", hi, 0);
        stage(1'b1, 3);
        update("R12 enable", 1'b1, 10);
        expect_runs("R12 div3", 3, 6);

        // R10: update issued during a high phase.
        stage(1'b1, 1);
        while (!card_clk) tick();
        exp_q.push_back(3);
        tag_q.push_back("R10 full high");
        command(1'b1, 1'b1, 1'b1);
        wait_clear("R10 applied", 10);
        expect_runs("R10 div1", 1, 6);
        clear_done();

        // R6: wait flag holds off while busy; without it busy is ignored.
        xfer_busy = 1'b1;
        stage(1'b1, 5);
        command(1'b1, 1'b1, 1'b1);
        repeat (30) tick();
        check("R6 held while busy", start_bit, 1);
        xfer_busy = 1'b0;
        wait_clear("R6 after busy", 4);
        expect_runs("R6 div5", 5, 4);
        clear_done();
        xfer_busy = 1'b1;
        stage(1'b1, 2);
        update("R6 no wait", 1'b0, 12);
        expect_runs("R6 div2", 2, 4);
        xfer_busy = 1'b0;

        // R8: divider 0 passes the module clock.
        stage(1'b1, 0);
        update("R8 pass", 1'b1, 10);
        repeat (3) tick();
        count_high(8, hi);
        check("R8 follows clk", hi, 8);

        // R11: largest divider value.
        stage(1'b1, DMAX);
        update("R11 max", 1'b1, 10);
        expect_runs("R11 div max", DMAX, 2);

        // R9: disable again.
        stage(1'b0, DMAX);
        update("R9 off", 1'b1, 2 * DMAX + 10);
        repeat (3) tick();
        count_high(20, hi);
        check("R9 off low", hi, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule